// File: doc/BRIEF.md
# Duty-Corrected Programmable Clock Divider

This block derives an output clock from a source clock by dividing it by a 7-bit ratio. Two ratio inputs are offered, and a select input picks the active one, so the output frequency can be changed while the clock runs. Any newly selected ratio, or a new value on the active input, is adopted only when the current output period ends.

Odd ratios produce a 50% duty cycle. A half-cycle-delayed copy of the rising-edge phase trims the high time to exactly N/2 source cycles. A ratio of zero parks the divider, drives the output low and drops the output-enable flag, so the pad can be tri-stated. A ratio of one forwards the source clock directly. A negative-phase option shifts every edge of the output by half a source cycle. Two outputs divided from the same source can then avoid switching together.

A second, smaller divider feeds an auxiliary output from the non-inverted source phase. It is controlled by a 2-bit code that selects off, /2, /3 or /4. That output is also duty-corrected and has its own enable flag.

Top module: `clkdiv_out`

## Requirements
- R1: `rst` is a synchronous, active-high reset. After a clock edge with `rst` high, `clk_out`, `out_oe`, `aux_clk` and `aux_oe` are all 0. The first edge with `rst` low starts a fresh output period at the selected ratio, and the output goes high at that edge.
- R2: For an even ratio N (2..126) the output period is N source cycles and the output is high for N/2 of them.
- R3: For an odd ratio N (3..127) the output period is N source cycles and the output is high for exactly N/2 cycles, that is N half-cycles.
- R4: For a ratio of 1, `clk_out` equals the source clock, or its inverse when `neg_phase` is 1.
- R5: For a ratio of 0, `out_oe` is 0 and `clk_out` stays low. A later non-zero ratio restarts the output.
- R6: The active ratio is `div_b` when `div_sel` is 1 and `div_a` when it is 0.
- R7: A change of `div_sel` or of the active ratio value is applied only at the end of the current output period. No high or low pulse shorter than the shorter half-period of the old and new ratios, less half a cycle, appears.
- R8: With `neg_phase` = 1 and a ratio of 2 or more, the output keeps its period and duty, and its edges move by half a source cycle.
- R9: `aux_mode` codes: 2'b00 gives an off output (`aux_oe` = 0, `aux_clk` low), 2'b01 divides by 4, 2'b10 divides by 2, and 2'b11 divides by 3 with 50% duty. A code change is applied at the end of the auxiliary period.
- R10: The auxiliary divider always uses the non-inverted source phase, whatever the value of `neg_phase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| div_a | input | 7 | Ratio used when `div_sel` is 0 (0 = off) |
| div_b | input | 7 | Ratio used when `div_sel` is 1 (0 = off) |
| div_sel | input | 1 | Selects which ratio input is active |
| neg_phase | input | 1 | Shifts the main output by half a source cycle |
| aux_mode | input | 2 | Auxiliary divider code |
| clk_out | output | 1 | Main divided clock |
| out_oe | output | 1 | Main output enable (0 = tri-state) |
| aux_clk | output | 1 | Auxiliary divided clock |
| aux_oe | output | 1 | Auxiliary output enable (0 = tri-state) |

## Verification
The bench samples each output twice per source cycle and measures every complete high and low run. It checks odd ratios, including 3 and 127, for runs of exactly N half-cycles. A design that skipped the half-cycle correction would show runs of N+1 and N-1.

The select input is switched between ratios 6 and 2 at six different points in the period. A design that adopted a new ratio at once would truncate a pulse, or let its counter run past the new limit and stretch a run far beyond either period.

The bench compares the sample phase of the first rising edge with and without the negative-phase option, so an option that had no effect, or that inverted the output, is caught. Ratios 0 and 1 are checked for a dead, disabled output and for an exact copy of the source clock. The auxiliary output is also checked to stay on the true phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of the auxiliary ratio (largest auxiliary ratio is 4)
  localparam int AUX_RW = 3;

  typedef enum logic [1:0] {
    AUX_OFF  = 2'b00,
    AUX_DIV4 = 2'b01,
    AUX_DIV2 = 2'b10,
    AUX_DIV3 = 2'b11
  } aux_mode_e;

  // How the shaping stage must build the output for the current ratio
  typedef enum logic [1:0] {
    SHP_IDLE,
    SHP_PASS,
    SHP_EVEN,
    SHP_ODD
  } shape_e;

  function automatic logic [AUX_RW-1:0] aux_ratio(input aux_mode_e m);
    case (m)
      AUX_DIV4: aux_ratio = AUX_RW'(4);
      AUX_DIV2: aux_ratio = AUX_RW'(2);
      AUX_DIV3: aux_ratio = AUX_RW'(3);
      default:  aux_ratio = '0;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_count.sv
module clkdiv_count
  import clkdiv_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  output logic [W-1:0] act,
  output logic [W-1:0] cnt,
  output logic         ph_pos,
  output shape_e       kind
);

  logic [W-1:0] act_q;
  logic [W-1:0] cnt_q;
  logic         ph_q;
  logic [W-1:0] cnt_inc;
  logic [W:0]   half_act;
  logic         wrap;

  assign cnt_inc  = cnt_q + W'(1);
  // High span in source cycles on the rising-edge phase: ceil(N/2)
  assign half_act = ({1'b0, act_q} + (W+1)'(1)) >> 1;
  // Period boundary: last count of a period, or parked at ratio zero
  assign wrap     = (act_q == '0) || (cnt_q == act_q - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (wrap) begin
      act_q <= req;
      cnt_q <= '0;
      ph_q  <= (req != '0);
    end else begin
      cnt_q <= cnt_inc;
      ph_q  <= ({1'b0, cnt_inc} < half_act);
    end
  end

  always_comb begin
    if (act_q == '0)          kind = SHP_IDLE;
    else if (act_q == W'(1))  kind = SHP_PASS;
    else if (act_q[0])        kind = SHP_ODD;
    else                      kind = SHP_EVEN;
  end

  assign act    = act_q;
  assign cnt    = cnt_q;
  assign ph_pos = ph_q;

endmodule

// File: rtl/clkdiv_shape.sv
module clkdiv_shape
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ph_pos,
  input  shape_e kind,
  input  logic   neg_phase,
  output logic   clk_o,
  output logic   oe_o
);

  logic ph_n;   // rising phase delayed half a cycle
  logic ph_pp;  // rising phase delayed a full cycle

  always_ff @(negedge clk) begin
    if (rst) ph_n <= 1'b0;
    else     ph_n <= ph_pos;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_pp <= 1'b0;
    else     ph_pp <= ph_n;
  end

  always_comb begin
    case (kind)
      SHP_PASS: clk_o = neg_phase ? ~clk : clk;
      SHP_EVEN: clk_o = neg_phase ? ph_n : ph_pos;
      // Odd: AND of two phases half a cycle apart trims the high span
      SHP_ODD:  clk_o = neg_phase ? (ph_n & ph_pp) : (ph_pos & ph_n);
      default:  clk_o = 1'b0;
    endcase
  end

  assign oe_o = (kind != SHP_IDLE);

endmodule

// File: rtl/clkdiv_aux.sv
module clkdiv_aux
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  output logic              clk_o,
  output logic              oe_o,
  output logic [AUX_RW-1:0] act_o,
  output logic [AUX_RW-1:0] cnt_o
);

  logic [AUX_RW-1:0] ratio_req;
  logic              ph_pos;
  shape_e            kind;

  assign ratio_req = aux_ratio(aux_mode_e'(mode));

  clkdiv_count #(.W(AUX_RW)) u_count (
    .clk    (clk),
    .rst    (rst),
    .req    (ratio_req),
    .act    (act_o),
    .cnt    (cnt_o),
    .ph_pos (ph_pos),
    .kind   (kind)
  );

  // Auxiliary path always runs on the true phase
  clkdiv_shape u_shape (
    .clk       (clk),
    .rst       (rst),
    .ph_pos    (ph_pos),
    .kind      (kind),
    .neg_phase (1'b0),
    .clk_o     (clk_o),
    .oe_o      (oe_o)
  );

endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter bit HAS_AUX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic             div_sel,
  input  logic             neg_phase,
  input  logic [1:0]       aux_mode,
  output logic             clk_out,
  output logic             out_oe,
  output logic             aux_clk,
  output logic             aux_oe
);

  logic [DIV_W-1:0]  req_ratio;
  logic [DIV_W-1:0]  main_act;
  logic [DIV_W-1:0]  main_cnt;
  logic              main_ph;
  shape_e            main_kind;
  logic [AUX_RW-1:0] aux_act;
  logic [AUX_RW-1:0] aux_cnt;

  assign req_ratio = div_sel ? div_b : div_a;

  clkdiv_count #(.W(DIV_W)) u_main_count (
    .clk    (clk),
    .rst    (rst),
    .req    (req_ratio),
    .act    (main_act),
    .cnt    (main_cnt),
    .ph_pos (main_ph),
    .kind   (main_kind)
  );

  clkdiv_shape u_main_shape (
    .clk       (clk),
    .rst       (rst),
    .ph_pos    (main_ph),
    .kind      (main_kind),
    .neg_phase (neg_phase),
    .clk_o     (clk_out),
    .oe_o      (out_oe)
  );

  generate
    if (HAS_AUX) begin : g_aux
      clkdiv_aux u_aux (
        .clk   (clk),
        .rst   (rst),
        .mode  (aux_mode),
        .clk_o (aux_clk),
        .oe_o  (aux_oe),
        .act_o (aux_act),
        .cnt_o (aux_cnt)
      );
    end else begin : g_no_aux
      assign aux_clk = 1'b0;
      assign aux_oe  = 1'b0;
      assign aux_act = '0;
      assign aux_cnt = '0;
    end
  endgenerate

endmodule

// File: rtl/clkdiv_out_chk.sv
module clkdiv_out_chk
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [DIV_W-1:0]  div_a,
  input logic [DIV_W-1:0]  div_b,
  input logic              div_sel,
  input logic [1:0]        aux_mode,
  input logic              clk_out,
  input logic              out_oe,
  input logic              aux_clk,
  input logic              aux_oe,
  input logic [DIV_W-1:0]  main_act,
  input logic [DIV_W-1:0]  main_cnt,
  input logic [AUX_RW-1:0] aux_act,
  input logic [AUX_RW-1:0] aux_cnt
);

  // R1: one edge in reset leaves every output low and disabled
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!clk_out && !out_oe && !aux_clk && !aux_oe));

  // R2: main counter stays inside the active period
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    (main_act != '0) |-> (main_cnt < main_act));

  // R9: auxiliary counter stays inside its period
  a_r9_aux_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    (aux_act != '0) |-> (aux_cnt < aux_act));

  // R5: a zero ratio that stays selected keeps the output dead
  a_r5_zero_dead: assert property (@(posedge clk) disable iff (rst)
    ((main_act == '0) && ((div_sel ? div_b : div_a) == '0)) |=> (!out_oe && !clk_out && (main_cnt == '0)));

  // R6: at a period boundary the selected ratio input is adopted
  a_r6_load_selected: assert property (@(posedge clk) disable iff (rst)
    ((main_act == '0) || (main_cnt == main_act - DIV_W'(1))) |=> (main_act == $past(div_sel ? div_b : div_a)));

  // R7: inside a period the active ratio never moves
  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    ((main_act != '0) && (main_cnt != main_act - DIV_W'(1))) |=> $stable(main_act));

  // R9: auxiliary code 00 held across an idle boundary keeps it off
  a_r9_aux_off: assert property (@(posedge clk) disable iff (rst)
    ((aux_act == '0) && (aux_mode == 2'b00)) |=> (!aux_oe && !aux_clk));

endmodule

bind clkdiv_out clkdiv_out_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .div_a    (div_a),
  .div_b    (div_b),
  .div_sel  (div_sel),
  .aux_mode (aux_mode),
  .clk_out  (clk_out),
  .out_oe   (out_oe),
  .aux_clk  (aux_clk),
  .aux_oe   (aux_oe),
  .main_act (main_act),
  .main_cnt (main_cnt),
  .aux_act  (aux_act),
  .aux_cnt  (aux_cnt)
);

// File: tb/test_clkdiv_out.sv
`timescale 1ns/1ps
module test_clkdiv_out;

  localparam int DW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] div_a = DW'(4);
  logic [DW-1:0] div_b = DW'(4);
  logic          div_sel = 1'b0;
  logic          neg_phase = 1'b0;
  logic [1:0]    aux_mode = 2'b00;
  logic          clk_out, out_oe, aux_clk, aux_oe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  bit smp  [0:2047];
  bit asmp [0:2047];
  int nsmp = 0;

  clkdiv_out i_clkdiv_out (
    .clk       (clk),
    .rst       (rst),
    .div_a     (div_a),
    .div_b     (div_b),
    .div_sel   (div_sel),
    .neg_phase (neg_phase),
    .aux_mode  (aux_mode),
    .clk_out   (clk_out),
    .out_oe    (out_oe),
    .aux_clk   (aux_clk),
    .aux_oe    (aux_oe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_range(input string req, input int got, input int lo, input int hi);
    vectors++;
    if (got < lo || got > hi) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  // Two samples per source cycle: mid-high and mid-low
  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1.25;
      smp[2*i]  = clk_out;
      asmp[2*i] = aux_clk;
      #2.5;
      smp[2*i+1]  = clk_out;
      asmp[2*i+1] = aux_clk;
    end
    nsmp = 2 * n;
  endtask

  // Complete run lengths in half-cycles and index of the first rising sample
  task automatic analyze(input bit use_aux, output int mn, output int mx, output int rise);
    int last_t;
    last_t = -1;
    mn = 9999;
    mx = 0;
    rise = -1;
    for (int i = 1; i < nsmp; i++) begin
      bit a, b;
      a = use_aux ? asmp[i-1] : smp[i-1];
      b = use_aux ? asmp[i] : smp[i];
      if (a != b) begin
        if (b && rise < 0) rise = i;
        if (last_t >= 0) begin
          if (i - last_t < mn) mn = i - last_t;
          if (i - last_t > mx) mx = i - last_t;
        end
        last_t = i;
      end
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_main(input int a, input int b, input bit sel, input bit inv);
    @(posedge clk);
    #1;
    div_a = DW'(a);
    div_b = DW'(b);
    div_sel = sel;
    neg_phase = inv;
  endtask

  task automatic t_reset();
    int bad;
    repeat (3) @(posedge clk);
    #1.25;
    check("R1 clk_out in reset", clk_out, 0);
    check("R1 out_oe in reset", out_oe, 0);
    check("R1 aux_clk in reset", aux_clk, 0);
    check("R1 aux_oe in reset", aux_oe, 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    capture(8);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      bit e;
      e = ((i / 4) % 2) == 0;
      if (smp[i] != e) bad++;
    end
    check("R1 first period after release", bad, 0);
  endtask

  task automatic t_ratio(input string req, input int n);
    int mn, mx, rise;
    set_main(n, 9, 1'b0, 1'b0);
    settle(300);
    capture(6 * n + 8);
    analyze(1'b0, mn, mx, rise);
    check({req, " shortest run"}, mn, n);
    check({req, " longest run"}, mx, n);
    check({req, " enable"}, out_oe, 1);
  endtask

  task automatic t_one();
    int bad;
    set_main(1, 9, 1'b0, 1'b0);
    settle(300);
    capture(10);
    bad = 0;
    for (int i = 0; i < 10; i++) if (smp[2*i] != 1'b1 || smp[2*i+1] != 1'b0) bad++;
    check("R4 ratio 1 follows clk", bad, 0);
    set_main(1, 9, 1'b0, 1'b1);
    settle(4);
    capture(10);
    bad = 0;
    for (int i = 0; i < 10; i++) if (smp[2*i] != 1'b0 || smp[2*i+1] != 1'b1) bad++;
    check("R4 ratio 1 inverted follows ~clk", bad, 0);
  endtask

  task automatic t_zero();
    int ones, mn, mx, rise;
    set_main(0, 9, 1'b0, 1'b0);
    settle(300);
    capture(40);
    ones = 0;
    for (int i = 0; i < nsmp; i++) if (smp[i]) ones++;
    check("R5 zero ratio output low", ones, 0);
    check("R5 zero ratio enable", out_oe, 0);
    set_main(5, 9, 1'b0, 1'b0);
    settle(20);
    capture(40);
    analyze(1'b0, mn, mx, rise);
    check("R5 restart after zero", mn, 5);
    check("R5 enable after zero", out_oe, 1);
  endtask

  task automatic t_select();
    int mn, mx, rise;
    set_main(4, 6, 1'b1, 1'b0);
    settle(300);
    capture(40);
    analyze(1'b0, mn, mx, rise);
    check("R6 sel=1 uses div_b", mn, 6);
    check("R6 sel=1 uses div_b max", mx, 6);
    set_main(4, 6, 1'b0, 1'b0);
    settle(20);
    capture(40);
    analyze(1'b0, mn, mx, rise);
    check("R6 sel=0 uses div_a", mn, 4);
    check("R6 sel=0 uses div_a max", mx, 4);
  endtask

  task automatic t_switch();
    for (int k = 0; k < 6; k++) begin
      int mn, mx, rise;
      set_main(6, 2, 1'b0, 1'b0);
      settle(300);
      fork
        capture(60);
        begin
          repeat (k + 6) @(posedge clk);
          #1;
          div_sel = 1'b1;
          repeat (13) @(posedge clk);
          #1;
          div_sel = 1'b0;
        end
      join
      analyze(1'b0, mn, mx, rise);
      check_range("R7 switch shortest run", mn, 1, 6);
      check_range("R7 switch longest run", mx, 2, 7);
    end
  endtask

  task automatic t_invert(input int n);
    int mn, mx, r0, r1;
    set_main(n, 9, 1'b0, 1'b0);
    settle(300);
    capture(40);
    analyze(1'b0, mn, mx, r0);
    check("R8 true-phase rise sample phase", r0 % 2, n % 2);
    set_main(n, 9, 1'b0, 1'b1);
    settle(20);
    capture(40);
    analyze(1'b0, mn, mx, r1);
    check("R8 negative-phase rise sample phase", r1 % 2, 1 - (n % 2));
    check("R8 negative-phase shortest run", mn, n);
    check("R8 negative-phase longest run", mx, n);
  endtask

  task automatic t_aux(input logic [1:0] code, input int n, input bit inv);
    int mn, mx, rise;
    @(posedge clk);
    #1;
    aux_mode = code;
    neg_phase = inv;
    settle(20);
    capture(40);
    analyze(1'b1, mn, mx, rise);
    check("R9 aux shortest run", mn, n);
    check("R9 aux longest run", mx, n);
    check("R9 aux enable", aux_oe, 1);
    if (n % 2 == 0) check("R10 aux rises on true phase", rise % 2, 0);
  endtask

  task automatic t_aux_off();
    int ones;
    @(posedge clk);
    #1;
    aux_mode = 2'b00;
    settle(20);
    capture(30);
    ones = 0;
    for (int i = 0; i < nsmp; i++) if (asmp[i]) ones++;
    check("R9 aux off output low", ones, 0);
    check("R9 aux off enable", aux_oe, 0);
  endtask

  task automatic t_mid_reset();
    int ones;
    set_main(6, 9, 1'b0, 1'b0);
    settle(40);
    rst = 1'b1;
    capture(5);
    ones = 0;
    for (int i = 2; i < nsmp; i++) if (smp[i]) ones++;
    check("R1 output low during mid-run reset", ones, 0);
    check("R1 enable low during mid-run reset", out_oe, 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    settle(20);
  endtask

  initial begin
    t_reset();
    t_ratio("R2 ratio 2", 2);
    t_ratio("R2 ratio 4", 4);
    t_ratio("R2 ratio 10", 10);
    t_ratio("R2 ratio 126", 126);
    t_ratio("R3 ratio 3", 3);
    t_ratio("R3 ratio 7", 7);
    t_ratio("R3 ratio 127", 127);
    t_one();
    t_zero();
    t_select();
    t_switch();
    t_invert(4);
    t_invert(5);
    t_aux(2'b01, 4, 1'b0);
    t_aux(2'b10, 2, 1'b0);
    t_aux(2'b11, 3, 1'b0);
    t_aux(2'b10, 2, 1'b1);
    t_aux_off();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule